// File: doc/BRIEF.md
# Iterative Unsigned Divider Unit

This block is the execution unit behind a quotient-only unsigned divide instruction. The pipeline presents a dividend, a divisor and the instruction word, then raises `start` for one cycle. The unit runs a restoring shift-subtract loop that retires one quotient bit per cycle. A fixed number of cycles later it presents the truncated quotient with a one-cycle `done` pulse. The `done` pulse also serves as the write enable for the destination register. No remainder is ever kept or shown.

A zero divisor is caught in the setup cycle. The unit then raises a one-cycle divide-by-zero exception in place of a result and goes back to idle. An `abort` input, driven when an interrupt is taken, drops the operation in flight without any write-back. The register file is never touched, so the same instruction can be issued again from the start. The unit also decodes the instruction word combinationally. It reports whether the word is this divide and which register holds the dividend and receives the quotient. The divisor always comes from register 0, and the unit produces no write to the condition flag.

Top module: `udiv_unit`

## Requirements
- R1: When `done` is high, `quotient` equals floor(dividend / divisor) of the operands sampled with the accepted start, for any 32-bit unsigned values with a nonzero divisor.
- R2: With a nonzero divisor and no abort, `done` is high for exactly one cycle, 34 clock edges after the edge that samples the accepted `start`. `quotient` keeps its value at all times except on the edge that raises `done`.
- R3: With a zero divisor, `div0_exc` is high for exactly one cycle, on the cycle after the start edge. `done` never rises for that operation, `busy` is low from that cycle onward, and `quotient` is unchanged.
- R4: `busy` is high on every cycle from the one after an accepted start until the unit returns to idle. It is low in the cycle where `done` or `div0_exc` is high.
- R5: A `start` sampled while `busy` is high is ignored. The running operation completes on schedule, with its own operands and register index.
- R6: If `abort` is sampled high while `busy` is high, `busy` drops on the next cycle and no `done` occurs. This holds even when the abort lands on the final cycle. `quotient` keeps its earlier value. If `abort` is sampled while idle, it has no effect on a `start` in the same cycle.
- R7: `insn_hit` is high exactly when insn[15:12] = 4'b0100 and insn[7:0] = 8'b10000100. `insn_rn` always equals insn[11:8].
- R8: While `done` is high, `wb_rn` equals insn[11:8] as sampled with the accepted start.
- R9: After synchronous reset, `busy`, `done` and `div0_exc` are low and `quotient` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a division (taken only when idle) |
| abort | input | 1 | Cancel the division in flight without write-back |
| insn | input | 16 | Instruction word for decode and destination index |
| dividend | input | 32 | Unsigned dividend, sampled with start |
| divisor | input | 32 | Unsigned divisor (register 0), sampled with start |
| insn_hit | output | 1 | Instruction word is this divide |
| insn_rn | output | 4 | Dividend/destination register field of insn |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle result strobe and write enable |
| quotient | output | 32 | Last completed quotient |
| wb_rn | output | 4 | Destination register index for the write-back |
| div0_exc | output | 1 | One-cycle divide-by-zero exception |

## Verification
The divide path is swept over every dividend from 0 to 63 against every divisor from 1 to 15. This covers quotients of zero, of one and of the dividend itself, with exact and inexact cases. The sweep runs inside the full 32-bit datapath, so the latency is timed on every operation. Full-width operands follow: all-ones over one, all-ones over all-ones, the top bit alone over three, and a set of pseudo-random pairs. These catch borrow and shift faults that only appear in the high bits. A zero divisor, an abort in the middle and one on the last cycle, and a start while busy then separate the exception, cancel and ignore paths from normal completion. The decoder is swept over all 65536 instruction words.

// File: rtl/divu_pkg.sv
package divu_pkg;

    localparam int DIVU_W = 32;

    localparam logic [3:0] OPC_TOP = 4'b0100;
    localparam logic [7:0] OPC_LOW = 8'b1000_0100;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RUN,
        ST_WB
    } div_state_e;

    typedef struct packed {
        logic       hit;
        logic [3:0] rn;
    } insn_dec_t;

    function automatic insn_dec_t decode_insn(input logic [15:0] w);
        insn_dec_t d;
        d.hit = (w[15:12] == OPC_TOP) && (w[7:0] == OPC_LOW);
        d.rn  = w[11:8];
        return d;
    endfunction

endpackage

// File: rtl/divu_decode.sv
module divu_decode
    import divu_pkg::*;
(
    input  logic [15:0] insn,
    output insn_dec_t   dec
);
    always_comb begin
        dec = decode_insn(insn);
    end

    // R7
    always_comb begin
        decode_field_chk: assert (dec.rn == insn[11:8]);
    end
endmodule

// File: rtl/divu_ctrl.sv
module divu_ctrl
    import divu_pkg::*;
#(
    parameter int W = DIVU_W
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    input  logic dsr_zero,
    output logic load,
    output logic step,
    output logic finish,
    output logic busy,
    output logic exc
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    div_state_e    state;
    logic [CW-1:0] cnt;

    always_comb begin
        busy   = (state != ST_IDLE);
        load   = (state == ST_IDLE) && start;
        step   = (state == ST_RUN) && !abort;
        finish = (state == ST_WB) && !abort;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            exc   <= 1'b0;
        end else begin
            exc <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) state <= ST_SETUP;
                end
                ST_SETUP: begin
                    if (abort) begin
                        state <= ST_IDLE;
                    end else if (dsr_zero) begin
                        state <= ST_IDLE;
                        exc   <= 1'b1;
                    end else begin
                        state <= ST_RUN;
                        cnt   <= '0;
                    end
                end
                ST_RUN: begin
                    if (abort) begin
                        state <= ST_IDLE;
                    end else if (cnt == LAST) begin
                        state <= ST_WB;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6
    abort_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && abort) |=> !busy);

    // R3
    zero_exc_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETUP && dsr_zero && !abort) |=> (exc && !busy));
endmodule

// File: rtl/divu_datapath.sv
module divu_datapath
    import divu_pkg::*;
#(
    parameter int W = DIVU_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic         finish,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    input  logic [3:0]   rn_in,
    output logic         dsr_zero,
    output logic [W-1:0] quotient,
    output logic         done,
    output logic [3:0]   wb_rn
);
    logic [W-1:0] rem_q;
    logic [W-1:0] quo_q;
    logic [W-1:0] dsr_q;
    logic [3:0]   rn_q;
    logic [W:0]   shifted;
    logic [W:0]   diff;
    logic         fits;

    always_comb begin
        dsr_zero = (dsr_q == '0);
        shifted  = {rem_q, quo_q[W-1]};
        diff     = shifted - {1'b0, dsr_q};
        fits     = !diff[W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q    <= '0;
            quo_q    <= '0;
            dsr_q    <= '0;
            rn_q     <= '0;
            quotient <= '0;
            done     <= 1'b0;
            wb_rn    <= '0;
        end else begin
            done <= finish;
            if (load) begin
                rem_q <= '0;
                quo_q <= dividend;
                dsr_q <= divisor;
                rn_q  <= rn_in;
            end else if (step) begin
                rem_q <= fits ? diff[W-1:0] : shifted[W-1:0];
                quo_q <= {quo_q[W-2:0], fits};
            end
            if (finish) begin
                quotient <= quo_q;
                wb_rn    <= rn_q;
            end
        end
    end

    // R2
    quot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(quotient));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/udiv_unit.sv
module udiv_unit
    import divu_pkg::*;
#(
    parameter int W = DIVU_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         abort,
    input  logic [15:0]  insn,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         insn_hit,
    output logic [3:0]   insn_rn,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [3:0]   wb_rn,
    output logic         div0_exc
);
    localparam int LAT = W + 2;
    localparam int LW  = $clog2(LAT + 1) + 1;

    insn_dec_t dec;
    logic      load;
    logic      step;
    logic      finish;
    logic      dsr_zero;

    divu_decode u_decode (
        .insn (insn),
        .dec  (dec)
    );

    always_comb begin
        insn_hit = dec.hit;
        insn_rn  = dec.rn;
    end

    divu_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .abort    (abort),
        .dsr_zero (dsr_zero),
        .load     (load),
        .step     (step),
        .finish   (finish),
        .busy     (busy),
        .exc      (div0_exc)
    );

    divu_datapath #(.W(W)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step),
        .finish   (finish),
        .dividend (dividend),
        .divisor  (divisor),
        .rn_in    (dec.rn),
        .dsr_zero (dsr_zero),
        .quotient (quotient),
        .done     (done),
        .wb_rn    (wb_rn)
    );

    logic [LW-1:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (rst)       lat_cnt <= '0;
        else if (load) lat_cnt <= '0;
        else if (busy) lat_cnt <= lat_cnt + 1'b1;
    end

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_cnt == LW'(LAT)));

    // R4
    idle_at_result_chk: assert property (@(posedge clk) disable iff (rst)
        (done || div0_exc) |-> !busy);

    // R3
    exc_no_done_chk: assert property (@(posedge clk) disable iff (rst)
        div0_exc |-> !done);

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !abort && !finish && !(div0_exc)) |=> (busy || done || div0_exc));
endmodule

// File: tb/test_udiv_unit.sv
module test_udiv_unit;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        abort;
    logic [15:0] insn;
    logic [31:0] dividend;
    logic [31:0] divisor;
    logic        insn_hit;
    logic [3:0]  insn_rn;
    logic        busy;
    logic        done;
    logic [31:0] quotient;
    logic [3:0]  wb_rn;
    logic        div0_exc;

    int n_chk = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    udiv_unit i_udiv_unit (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .abort    (abort),
        .insn     (insn),
        .dividend (dividend),
        .divisor  (divisor),
        .insn_hit (insn_hit),
        .insn_rn  (insn_rn),
        .busy     (busy),
        .done     (done),
        .quotient (quotient),
        .wb_rn    (wb_rn),
        .div0_exc (div0_exc)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_insn(input logic [3:0] rn);
        return {4'b0100, rn, 8'b1000_0100};
    endfunction

    // Issue one operation and wait for done or exception (or timeout).
    task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic [3:0] rn,
                         output int lat, output bit busy_ok);
        @(negedge clk);
        start    = 1'b1;
        dividend = a;
        divisor  = b;
        insn     = mk_insn(rn);
        @(posedge clk);
        lat     = 0;
        busy_ok = 1'b1;
        @(negedge clk);
        start = 1'b0;
        insn  = 16'h0000;
        while (!done && !div0_exc && lat < 80) begin
            if (!busy) busy_ok = 1'b0;
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    task automatic full_div(input logic [31:0] a, input logic [31:0] b, input logic [3:0] rn);
        int lat;
        bit bok;
        issue(a, b, rn, lat, bok);
        chk(done == 1'b1 && div0_exc == 1'b0, "R2", "done seen", {62'd0, done, div0_exc}, 64'd2);
        chk(lat == 34, "R2", "latency", 64'(lat), 64'd34);
        chk(quotient == a / b, "R1", "quotient", 64'(quotient), 64'(a / b));
        chk(wb_rn == rn, "R8", "wb_rn", 64'(wb_rn), 64'(rn));
        chk(bok && !busy, "R4", "busy span", {62'd0, bok, busy}, 64'd2);
        @(negedge clk);
        chk(!done, "R2", "done single cycle", 64'(done), 64'd0);
    endtask

    initial begin
        #(PERIOD * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        logic [31:0] lfsr_a;
        logic [31:0] lfsr_b;
        int lat;
        bit bok;
        bit seen;

        rst = 1'b1; start = 1'b0; abort = 1'b0; insn = '0; dividend = '0; divisor = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        chk(!busy && !done && !div0_exc, "R9", "flags after reset",
            {61'd0, busy, done, div0_exc}, 64'd0);
        chk(quotient == 32'd0, "R9", "quotient after reset", 64'(quotient), 64'd0);

        // R7 decode sweep over all instruction words
        for (int w = 0; w < 65536; w++) begin
            bit exp_hit;
            insn = w[15:0];
            #1;
            exp_hit = (w[15:12] == 4'd4) && (w[7:0] == 8'h84);
            chk(insn_hit == exp_hit && insn_rn == w[11:8], "R7", "decode",
                {59'd0, insn_hit, insn_rn}, {59'd0, exp_hit, 4'(w[11:8])});
        end
        insn = '0;

        // R1 R2 R4 R8 small exhaustive sweep
        for (int a = 0; a < 64; a++) begin
            for (int b = 1; b < 16; b++) begin
                full_div(32'(a), 32'(b), 4'(a + b));
            end
        end

        // R1 full-width corners
        full_div(32'hFFFF_FFFF, 32'd1, 4'd1);
        full_div(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd2);
        full_div(32'h8000_0000, 32'd3, 4'd3);
        full_div(32'd7, 32'hFFFF_FFFF, 4'd4);
        full_div(32'hFFFF_FFFE, 32'h8000_0001, 4'd15);
        lfsr_a = 32'h1234_5678;
        lfsr_b = 32'h0BAD_F00D;
        for (int i = 0; i < 150; i++) begin
            lfsr_a = lfsr_a * 32'd1664525 + 32'd1013904223;
            lfsr_b = lfsr_b * 32'd22695477 + 32'd1;
            full_div(lfsr_a, (lfsr_b >> (i % 31)) | 32'd1, 4'(i));
        end

        // R3 zero divisor
        held = quotient;
        issue(32'd1234, 32'd0, 4'd6, lat, bok);
        chk(div0_exc && !done, "R3", "exception raised", {62'd0, div0_exc, done}, 64'd2);
        chk(lat == 1, "R3", "exception timing", 64'(lat), 64'd1);
        chk(!busy, "R3", "idle with exception", 64'(busy), 64'd0);
        seen = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (done || div0_exc) seen = 1'b1;
        end
        chk(!seen && quotient == held, "R3", "no result after exception",
            64'(quotient), 64'(held));

        // R6 abort mid-operation
        held = quotient;
        @(negedge clk);
        start = 1'b1; dividend = 32'd1000; divisor = 32'd7; insn = mk_insn(4'd9);
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(!busy, "R6", "busy drops after abort", 64'(busy), 64'd0);
        seen = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        chk(!seen, "R6", "no done after abort", 64'(seen), 64'd0);
        chk(quotient == held, "R6", "quotient kept after abort", 64'(quotient), 64'(held));

        // R6 abort on the final cycle (sampled on edge 34)
        @(negedge clk);
        start = 1'b1; dividend = 32'd999; divisor = 32'd10; insn = mk_insn(4'd5);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (33) @(negedge clk);
        chk(busy && !done, "R6", "still running before last edge", {62'd0, busy, done}, 64'd2);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(!done && !busy, "R6", "late abort suppresses done", {62'd0, done, busy}, 64'd0);
        chk(quotient == held, "R6", "quotient kept after late abort", 64'(quotient), 64'(held));

        // R6 reissue after abort yields the full result
        full_div(32'd999, 32'd10, 4'd5);

        // R6 abort while idle with a start in the same cycle
        @(negedge clk);
        start = 1'b1; abort = 1'b1; dividend = 32'd500; divisor = 32'd4; insn = mk_insn(4'd8);
        @(posedge clk);
        lat = 0;
        @(negedge clk);
        start = 1'b0; abort = 1'b0;
        chk(busy, "R6", "idle abort does not block start", 64'(busy), 64'd1);
        while (!done && lat < 80) begin
            @(posedge clk); lat++; @(negedge clk);
        end
        chk(lat == 34 && quotient == 32'd125, "R6", "result with idle abort",
            64'(quotient), 64'd125);

        // R5 start while busy is ignored
        @(negedge clk);
        start = 1'b1; dividend = 32'd300; divisor = 32'd7; insn = mk_insn(4'd11);
        @(posedge clk);
        lat = 0;
        @(negedge clk);
        start = 1'b0;
        repeat (4) begin @(posedge clk); lat++; @(negedge clk); end
        start = 1'b1; dividend = 32'd90; divisor = 32'd2; insn = mk_insn(4'd12);
        @(posedge clk); lat++; @(negedge clk);
        start = 1'b0;
        while (!done && lat < 80) begin
            @(posedge clk); lat++; @(negedge clk);
        end
        chk(lat == 34, "R5", "latency unaffected", 64'(lat), 64'd34);
        chk(quotient == 32'd42, "R5", "first operands kept", 64'(quotient), 64'd42);
        chk(wb_rn == 4'd11, "R5", "first register kept", 64'(wb_rn), 64'd11);
        seen = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (done || busy) seen = 1'b1;
        end
        chk(!seen, "R5", "no second operation", 64'(seen), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule